// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron

This block holds the state of a single spiking neuron that advances in discrete time steps. A step strobe carries the summed synaptic input for that step. On an accepted step the neuron adds that input to its signed fixed-point membrane potential, saturating at the signed range limits. It then pulls the potential toward a resting value by a constant leak magnitude, and compares the result with a threshold. When the leaked potential is above the threshold the neuron fires, and a one-cycle spike appears on the output.

After a spike the potential is either forced to a configured reset value (hard mode) or lowered by the threshold (soft mode). A refractory counter then blocks the following steps. All tuning values are plain configuration inputs, sampled on the cycle of each strobe. The step input has no back-pressure: every cycle with the strobe high is one time step. The caller holds the strobe low on cycles that are not steps.

Top module: `lif_neuron`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, the membrane potential output equals the resting value input, the spike output is low and the refractory flag is low.
- R2: On a step with the refractory counter at zero, the signed synaptic input is added to the membrane potential before the leak is applied.
- R3: The addition saturates: a sum above the largest signed W-bit value becomes that value, and a sum below the smallest becomes the smallest. It never wraps.
- R4: After the addition, the leak moves the potential toward the resting value by the unsigned leak magnitude and stops at the resting value, never crossing it. A potential equal to rest is unchanged.
- R5: The neuron fires when the leaked potential is strictly greater than the signed threshold. The spike output is high for exactly the one cycle that follows the clock edge of the firing strobe.
- R6: With the reset-mode input at 0 (hard), a firing step leaves the potential at the reset value input.
- R7: With the reset-mode input at 1 (soft), a firing step leaves the potential at the leaked potential minus the threshold, saturated to the signed range.
- R8: A firing step loads the refractory counter with the refractory length input. While the counter is nonzero, a step ignores its synaptic input, holds the potential, cannot fire, and lowers the counter by one. The refractory flag is high exactly while the counter is nonzero. A length of 0 allows firing on the very next step.
- R9: A cycle without the strobe changes neither the potential nor the counter, and the spike output stays low after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_valid_i | input | 1 | Time-step strobe; one step per high cycle |
| syn_i | input | W | Signed summed synaptic input for this step |
| thr_i | input | W | Signed firing threshold |
| leak_i | input | W | Unsigned leak magnitude per step |
| rest_i | input | W | Signed resting potential |
| reset_val_i | input | W | Signed potential loaded on a hard-reset spike |
| soft_mode_i | input | 1 | 0 = hard reset, 1 = soft (subtract threshold) |
| refr_len_i | input | RW | Refractory length in steps |
| vm_o | output | W | Signed membrane potential |
| spike_o | output | 1 | One-cycle spike pulse |
| refr_busy_o | output | 1 | High while the refractory counter is nonzero |

## Verification
The bench builds the neuron with W = 8 and RW = 3. The signed range is then only -128..127, so random inputs of up to ±127 push the sum against both saturation limits often. The 3-bit counter lets random refractory lengths cover every value from 0 to its maximum of 7, including back-to-back firing at length 0. Directed sequences drive the potential to each rail and test the hard and soft reset paths. The other cases come from random steps, idle cycles and configuration changes.

// File: rtl/lif_pkg.sv
package lif_pkg;

  typedef enum logic {
    RESET_HARD = 1'b0,
    RESET_SOFT = 1'b1
  } reset_mode_e;

endpackage

// File: rtl/lif_integrate.sv
// Adds the step input with saturation, then leaks toward rest without overshoot.
module lif_integrate #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] v_i,
  input  logic signed [W-1:0] syn_i,
  input  logic signed [W-1:0] rest_i,
  input  logic        [W-1:0] leak_i,
  output logic signed [W-1:0] sum_o,
  output logic signed [W-1:0] leaked_o
);
  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] MAXV = XW'((64'd1 << (W - 1)) - 64'd1);
  localparam logic signed [XW-1:0] MINV = ~MAXV;

  logic signed [XW-1:0] raw;
  logic signed [XW-1:0] sum_x;
  logic signed [XW-1:0] rest_x;
  logic signed [XW-1:0] leak_x;
  logic signed [XW-1:0] moved;
  logic signed [XW-1:0] leaked_x;

  always_comb begin
    raw    = XW'(v_i) + XW'(syn_i);
    rest_x = XW'(rest_i);
    leak_x = {2'b00, leak_i};

    if (raw > MAXV)      sum_x = MAXV;
    else if (raw < MINV) sum_x = MINV;
    else                 sum_x = raw;

    if (sum_x > rest_x) begin
      moved    = sum_x - leak_x;
      leaked_x = (moved < rest_x) ? rest_x : moved;
    end else if (sum_x < rest_x) begin
      moved    = sum_x + leak_x;
      leaked_x = (moved > rest_x) ? rest_x : moved;
    end else begin
      moved    = sum_x;
      leaked_x = sum_x;
    end

    sum_o    = W'(sum_x);
    leaked_o = W'(leaked_x);
  end

endmodule

// File: rtl/lif_fire.sv
// Threshold compare and post-spike potential for either reset mode.
module lif_fire
  import lif_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] leaked_i,
  input  logic signed [W-1:0] thr_i,
  input  logic signed [W-1:0] reset_val_i,
  input  reset_mode_e         mode_i,
  output logic                fire_o,
  output logic signed [W-1:0] next_v_o
);
  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] MAXV = XW'((64'd1 << (W - 1)) - 64'd1);
  localparam logic signed [XW-1:0] MINV = ~MAXV;

  logic signed [XW-1:0] diff;
  logic signed [W-1:0]  soft_v;

  always_comb begin
    fire_o = (leaked_i > thr_i);
    diff   = XW'(leaked_i) - XW'(thr_i);
    if (diff > MAXV)      soft_v = W'(MAXV);
    else if (diff < MINV) soft_v = W'(MINV);
    else                  soft_v = W'(diff);

    if (!fire_o)                   next_v_o = leaked_i;
    else if (mode_i == RESET_SOFT) next_v_o = soft_v;
    else                           next_v_o = reset_val_i;
  end

endmodule

// File: rtl/lif_refractory.sv
// Step-counted refractory window.
module lif_refractory #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic          fire_i,
  input  logic [RW-1:0] len_i,
  output logic [RW-1:0] cnt_o,
  output logic          busy_o
);
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (step_i && busy_o)   cnt_q <= cnt_q - RW'(1);
    else if (step_i && fire_i)   cnt_q <= len_i;
  end

  assign busy_o = (cnt_q != '0);
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/lif_neuron.sv
module lif_neuron
  import lif_pkg::*;
#(
  parameter int W  = 16,
  parameter int RW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_valid_i,
  input  logic signed [W-1:0] syn_i,
  input  logic signed [W-1:0] thr_i,
  input  logic        [W-1:0] leak_i,
  input  logic signed [W-1:0] rest_i,
  input  logic signed [W-1:0] reset_val_i,
  input  logic                soft_mode_i,
  input  logic [RW-1:0]       refr_len_i,
  output logic signed [W-1:0] vm_o,
  output logic                spike_o,
  output logic                refr_busy_o
);
  logic signed [W-1:0] v_q;
  logic                spike_q;
  logic signed [W-1:0] sum_w;
  logic signed [W-1:0] leaked_w;
  logic signed [W-1:0] next_v_w;
  logic                fire_w;
  logic                busy_w;
  logic                take_w;
  logic                fire_go_w;
  logic [RW-1:0]       refr_cnt_w;
  reset_mode_e         mode_w;

  assign mode_w    = reset_mode_e'(soft_mode_i);
  assign take_w    = step_valid_i && !busy_w;
  assign fire_go_w = take_w && fire_w;

  lif_integrate #(.W(W)) u_integrate (
    .v_i      (v_q),
    .syn_i    (syn_i),
    .rest_i   (rest_i),
    .leak_i   (leak_i),
    .sum_o    (sum_w),
    .leaked_o (leaked_w)
  );

  lif_fire #(.W(W)) u_fire (
    .leaked_i    (leaked_w),
    .thr_i       (thr_i),
    .reset_val_i (reset_val_i),
    .mode_i      (mode_w),
    .fire_o      (fire_w),
    .next_v_o    (next_v_w)
  );

  lif_refractory #(.RW(RW)) u_refr (
    .clk    (clk),
    .rst    (rst),
    .step_i (step_valid_i),
    .fire_i (fire_go_w),
    .len_i  (refr_len_i),
    .cnt_o  (refr_cnt_w),
    .busy_o (busy_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q     <= rest_i;
      spike_q <= 1'b0;
    end else begin
      spike_q <= fire_go_w;
      if (take_w) v_q <= next_v_w;
    end
  end

  assign vm_o        = v_q;
  assign spike_o     = spike_q;
  assign refr_busy_o = busy_w;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_valid_i |=> ($stable(vm_o) && !spike_o)); // R9
  AST_REFR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (step_valid_i && busy_w) |=> ($stable(vm_o) && !spike_o)); // R8
  AST_REFR_COUNT: assert property (@(posedge clk) disable iff (rst)
    (step_valid_i && busy_w) |=> (refr_cnt_w == $past(refr_cnt_w) - RW'(1))); // R8
  AST_SPIKE_FROM_STEP: assert property (@(posedge clk) disable iff (rst)
    spike_o |-> ($past(step_valid_i) && ($past(leaked_w) > $past(thr_i)))); // R5
  AST_HARD_RESET: assert property (@(posedge clk) disable iff (rst)
    (spike_o && !$past(soft_mode_i)) |-> (vm_o == $past(reset_val_i))); // R6
  AST_LEAK_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (rst)
    (take_w && sum_w >= rest_i) |-> (leaked_w >= rest_i && leaked_w <= sum_w)); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (take_w && !v_q[W-1] && !syn_i[W-1]) |-> (sum_w >= v_q)); // R3

endmodule

// File: tb/test_lif_neuron.sv
module test_lif_neuron;
  localparam int W = 8;
  localparam int RW = 3;
  localparam int CLK_PERIOD = 10;
  localparam int HI = (1 << (W - 1)) - 1;
  localparam int LO = -(1 << (W - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_valid_i = 1'b0;
  logic signed [W-1:0] syn_i = '0;
  logic signed [W-1:0] thr_i = '0;
  logic [W-1:0] leak_i = '0;
  logic signed [W-1:0] rest_i = '0;
  logic signed [W-1:0] reset_val_i = '0;
  logic soft_mode_i = 1'b0;
  logic [RW-1:0] refr_len_i = '0;
  logic signed [W-1:0] vm_o;
  logic spike_o;
  logic refr_busy_o;

  int checks = 0;
  int failures = 0;
  int m_v, m_cnt;
  int c_thr, c_leak, c_rest, c_rv, c_mode, c_len;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lif_neuron #(.W(W), .RW(RW)) i_lif_neuron (
    .clk(clk), .rst(rst), .step_valid_i(step_valid_i), .syn_i(syn_i),
    .thr_i(thr_i), .leak_i(leak_i), .rest_i(rest_i), .reset_val_i(reset_val_i),
    .soft_mode_i(soft_mode_i), .refr_len_i(refr_len_i),
    .vm_o(vm_o), .spike_o(spike_o), .refr_busy_o(refr_busy_o)
  );

  function automatic int clampw(int x);
    if (x > HI) return HI;
    if (x < LO) return LO;
    return x;
  endfunction

  function automatic int leak_to(int s, int rest, int lk);
    int d;
    if (s > rest) begin d = s - lk; return (d < rest) ? rest : d; end
    if (s < rest) begin d = s + lk; return (d > rest) ? rest : d; end
    return s;
  endfunction

  task automatic chk(string req, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic apply_cfg();
    thr_i       = c_thr[W-1:0];
    leak_i      = c_leak[W-1:0];
    rest_i      = c_rest[W-1:0];
    reset_val_i = c_rv[W-1:0];
    soft_mode_i = c_mode[0];
    refr_len_i  = c_len[RW-1:0];
  endtask

  // Called at a negedge; drives one cycle and checks at the next negedge.
  task automatic cycle(bit sv, int syn);
    int s, l, exp_spike;
    string tag;
    apply_cfg();
    step_valid_i = sv;
    syn_i = syn[W-1:0];
    exp_spike = 0;
    if (!sv) tag = "R9";
    else if (m_cnt != 0) begin
      tag = "R8";
      m_cnt--;
    end else begin
      s = clampw(m_v + syn);
      l = leak_to(s, c_rest, c_leak);
      if (l > c_thr) begin
        exp_spike = 1;
        tag = c_mode[0] ? "R7" : "R6";
        m_v = c_mode[0] ? clampw(l - c_thr) : c_rv;
        m_cnt = c_len;
      end else begin
        if (m_v + syn != s) tag = "R3";
        else if (l != s) tag = "R4";
        else tag = "R2";
        m_v = l;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, int'(vm_o), m_v, "vm");
    chk("R5", int'(spike_o), exp_spike, "spike");
    chk("R8", int'(refr_busy_o), int'(m_cnt != 0), "refr_busy");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    c_thr = 50; c_leak = 2; c_rest = -5; c_rv = -20; c_mode = 0; c_len = 2;
    apply_cfg();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(vm_o), -5, "vm in reset");
    chk("R1", int'(spike_o), 0, "spike in reset");
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1", int'(vm_o), -5, "vm after reset");
    chk("R1", int'(refr_busy_o), 0, "refr after reset");
    m_v = -5; m_cnt = 0;

    // R3: drive into both rails with no leak, threshold unreachable.
    c_thr = HI; c_leak = 0; c_rest = 0; c_len = 0;
    cycle(1, 127); cycle(1, 127); cycle(1, 100);
    cycle(1, -128); cycle(1, -128); cycle(1, -128);
    // R4: leak toward rest from below, clamp at rest.
    c_leak = 60;
    cycle(1, 0); cycle(1, 0); cycle(1, 0);
    // R2: plain add with no leak.
    c_leak = 0;
    cycle(1, 17); cycle(1, -9); cycle(0, 55);
    // R6: hard reset then refractory (R8), input ignored.
    c_thr = 30; c_rv = -12; c_mode = 0; c_len = 3;
    cycle(1, 40); cycle(1, 100); cycle(0, 100); cycle(1, 100); cycle(1, 100);
    // R7: soft reset, length 0 allows back-to-back firing.
    c_mode = 1; c_len = 0;
    cycle(1, 100); cycle(1, 100); cycle(1, 100);

    for (int i = 0; i < 4000; i++) begin
      int syn;
      if ($urandom_range(0, 19) == 0) begin
        c_thr  = int'($urandom_range(5, 100));
        c_leak = int'($urandom_range(0, 7));
        c_rest = int'($urandom_range(0, 20)) - 10;
        c_rv   = int'($urandom_range(0, 40)) - 20;
        c_mode = int'($urandom_range(0, 1));
        c_len  = int'($urandom_range(0, 7));
      end
      if ($urandom_range(0, 9) == 0) syn = ($urandom_range(0, 1) != 0) ? 127 : -128;
      else syn = int'($urandom_range(0, 80)) - 40;
      cycle($urandom_range(0, 9) < 7, syn);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule